// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for every incoming Ethernet frame, whether the frame is kept, and it does so by looking only at the 48-bit destination address. The receive datapath presents the first six octets of the frame one per cycle. A qualifier marks each valid octet, and a start strobe comes with the first one. One clock after the sixth octet is taken, the block gives a single-cycle verdict. The verdict is an accept bit plus a 2-bit destination class, which the surrounding receive logic later places into bits 24:23 of its per-frame status word.

Software reaches the filter through a two-register indirect window. The select register holds an index into the station-address words. Its top bits also hold the global enable and four accept-mode flags. The data register reads or writes the station-address word that the index points at. The station address is stored as three 16-bit words, each made of two octets. The mode flags may only be altered while the filter is disabled, so software disables the filter, programs it, and then enables it again.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset the filter is disabled, all mode flags are clear, both registers read zero, and every frame is rejected with class 00.
- R2: With cfg_sel=1, the station-address word at select index 0, 2 or 4 is written and read. That word holds address octets 0-1, 2-3 or 4-5, with the earlier octet in bits 7:0 and the later octet in bits 15:8. Any other index ignores writes and reads as zero.
- R3: With cfg_sel=0, a read returns the enable in bit 31, the broadcast, multicast, unicast and exact-match flags in bits 30, 29, 28 and 27, the select index in bits 3:0, and zero elsewhere.
- R4: A select-register write made while the filter is enabled updates the enable and the index but leaves bits 30:27 unchanged.
- R5: While the enable bit is clear, every frame is rejected with class 00.
- R6: res_valid is high for exactly one cycle, the cycle after the sixth destination octet is taken. Further octets are ignored until the next start strobe.
- R7: Class encoding: 11 = broadcast (all 48 bits one), 10 = multicast (bit 0 of octet 0 set, not broadcast), 01 = unicast, 00 = rejected. Broadcast is decided before multicast.
- R8: A frame is accepted when the filter is enabled and at least one of these holds: it is broadcast with bit 30 set, multicast with bit 29 set, unicast with bit 28 set, or exactly equal to the station address with bit 27 set.
- R9: A start strobe in the middle of a frame drops the partial comparison and begins a new frame with that octet as octet 0.
- R10: Cycles with rx_valid low between octets neither advance nor disturb the comparison.
- R11: The verdict uses the configuration present in the cycle the sixth octet is taken. A configuration write in that same cycle affects only later frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = select register, 1 = data register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the register chosen by cfg_sel |
| rx_valid | input | 1 | An octet is present on rx_byte |
| rx_sof | input | 1 | Marks octet 0 of a frame (with rx_valid) |
| rx_byte | input | 8 | Destination octet |
| res_valid | output | 1 | Verdict strobe |
| res_accept | output | 1 | Frame accepted |
| res_class | output | 2 | Destination class |

## Verification
Two functions can fall in the same cycle: a configuration write and the sixth octet of a frame. The bench provokes this by driving the final octet and a disabling select-register write on the same clock edge. It expects the frame to be judged by the settings that were in force before the write, and it expects the next frame to be rejected. A start strobe that arrives while a frame is partly compared is also provoked, and the bench expects the verdict to reflect only the new frame.

// File: rtl/rx_dest_filter.sv
module rx_dest_filter #(
  parameter int WORDS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic [7:0]  rx_byte,
  output logic        res_valid,
  output logic        res_accept,
  output logic [1:0]  res_class
);
  localparam int OCT = 2 * WORDS;
  localparam int CW  = $clog2(OCT + 1);

  logic        en;
  logic [3:0]  mode;
  logic [3:0]  idx;
  logic [15:0] stn [WORDS];
  logic [15:0] word_rd;

  logic [CW-1:0] cnt;
  logic          eq_r, bc_r, grp_r;
  logic [7:0]    stn_oct;
  logic [1:0]    cls;

  logic unused_bits;
  assign unused_bits = ^cfg_wdata[26:16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      mode <= '0;
      idx  <= '0;
      for (int w = 0; w < WORDS; w++) stn[w] <= '0;
    end else if (cfg_wr) begin
      if (!cfg_sel) begin
        en  <= cfg_wdata[31];
        idx <= cfg_wdata[3:0];
        if (!en) mode <= cfg_wdata[30:27];
      end else begin
        for (int w = 0; w < WORDS; w++)
          if (idx == 4'(2 * w)) stn[w] <= cfg_wdata[15:0];
      end
    end
  end

  always_comb begin
    word_rd = '0;
    for (int w = 0; w < WORDS; w++)
      if (idx == 4'(2 * w)) word_rd = stn[w];
  end

  assign cfg_rdata = cfg_sel ? {16'b0, word_rd} : {en, mode, 23'b0, idx};

  wire          take = rx_valid & (rx_sof | (cnt != CW'(OCT)));
  wire [CW-1:0] pos  = rx_sof ? '0 : cnt;
  wire          last = take & (pos == CW'(OCT - 1));

  always_comb begin
    stn_oct = '0;
    for (int w = 0; w < WORDS; w++)
      if (pos[CW-1:1] == (CW-1)'(w))
        stn_oct = pos[0] ? stn[w][15:8] : stn[w][7:0];
  end

  wire eq_n  = (rx_sof | eq_r) & (rx_byte == stn_oct);
  wire bc_n  = (rx_sof | bc_r) & (&rx_byte);
  wire grp_n = rx_sof ? rx_byte[0] : grp_r;

  wire is_bc = bc_n;
  wire is_mc = grp_n & ~bc_n;
  wire is_uc = ~grp_n;
  wire hit   = en & ((is_bc & mode[3]) | (is_mc & mode[2]) |
                     (is_uc & mode[1]) | (eq_n & mode[0]));

  always_comb begin
    if (!hit)       cls = 2'b00;
    else if (is_bc) cls = 2'b11;
    else if (is_mc) cls = 2'b10;
    else            cls = 2'b01;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= CW'(OCT);
      eq_r       <= 1'b0;
      bc_r       <= 1'b0;
      grp_r      <= 1'b0;
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_class  <= 2'b00;
    end else begin
      if (take) begin
        cnt   <= pos + 1'b1;
        eq_r  <= eq_n;
        bc_r  <= bc_n;
        grp_r <= grp_n;
      end
      res_valid  <= last;
      res_accept <= last & hit;
      res_class  <= last ? cls : 2'b00;
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);                                   // R6
  AST_AFTER_OCTET: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(rx_valid));                              // R6
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(mode));                        // R4
  AST_DISABLED_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    res_accept |-> $past(en));                                   // R5
  AST_CLASS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_accept == (res_class != 2'b00)));          // R7
endmodule

// File: tb/test_rx_dest_filter.sv
`timescale 1ns/1ps
module test_rx_dest_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic rx_valid = 0, rx_sof = 0;
  logic [7:0] rx_byte = '0;
  logic res_valid, res_accept;
  logic [1:0] res_class;

  always #2.5 clk = ~clk;

  rx_dest_filter i_rx_dest_filter (.*);

  int n_cmp = 0, n_bad = 0;
  logic [15:0] m_stn [3];
  logic m_en = 0;
  logic [3:0] m_mode = 0, m_idx = 0;
  logic [31:0] rd;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(logic sel, logic [31:0] d);
    if (!sel) begin
      if (!m_en) m_mode = d[30:27];
      m_en = d[31];
      m_idx = d[3:0];
    end else begin
      for (int w = 0; w < 3; w++) if (m_idx == 4'(2 * w)) m_stn[w] = d[15:0];
    end
  endtask

  task automatic cfg_write(logic sel, logic [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
    model_wr(sel, d);
  endtask

  task automatic cfg_read(logic sel, output logic [31:0] d);
    @(negedge clk); cfg_sel = sel; #1 d = cfg_rdata;
  endtask

  function automatic logic [2:0] expect_res(logic [47:0] d);
    logic bc, mc, uc, eq, hit;
    bc = &d; mc = d[0] & ~bc; uc = ~d[0];
    eq = (d == {m_stn[2], m_stn[1], m_stn[0]});
    hit = m_en & ((bc & m_mode[3]) | (mc & m_mode[2]) | (uc & m_mode[1]) | (eq & m_mode[0]));
    if (!hit) return 3'b000;
    return {1'b1, bc ? 2'b11 : mc ? 2'b10 : 2'b01};
  endfunction

  task automatic drive_octets(logic [47:0] d, int first, int cnt, bit gaps);
    for (int i = first; i < first + cnt; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        @(negedge clk); rx_valid = 0; rx_sof = 0; rx_byte = 8'($urandom);
      end
      @(negedge clk); rx_valid = 1; rx_sof = (i == 0); rx_byte = d[8*i +: 8];
    end
  endtask

  task automatic send_frame(string req, logic [47:0] d, bit gaps);
    logic [2:0] e;
    e = expect_res(d);
    drive_octets(d, 0, 6, gaps);
    @(negedge clk); rx_valid = 0; rx_sof = 0;
    check({req, " verdict"}, {res_valid, res_accept, res_class}, {1'b1, e});
    @(negedge clk);
    check("R6 pulse width", {31'b0, res_valid}, 32'd0);
  endtask

  function automatic logic [47:0] pick_addr();
    logic [47:0] a;
    a = {$urandom, $urandom};
    case ($urandom % 5)
      0: a = '1;
      1: a = {m_stn[2], m_stn[1], m_stn[0]};
      2: begin a = {m_stn[2], m_stn[1], m_stn[0]}; a[8*($urandom % 6) +: 8] ^= 8'h10; end
      3: a[0] = 1'b1;
      default: a[0] = 1'b0;
    endcase
    return a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R6 watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] st;
    logic [2:0] e;
    void'($urandom(32'h5eed_0042));
    for (int w = 0; w < 3; w++) m_stn[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    cfg_read(0, rd); check("R1 select reg", rd, 32'h0);
    cfg_read(1, rd); check("R1 data reg", rd, 32'h0);
    send_frame("R1", 48'hFFFF_FFFF_FFFF, 0);

    st = 48'h5544_3322_1102;
    for (int w = 0; w < 3; w++) begin
      cfg_write(0, 32'(2 * w));
      cfg_write(1, {16'h0, st[16*w +: 16]});
    end
    cfg_write(0, 32'h2); cfg_read(1, rd); check("R2 word 2-3", rd, 32'h3322);
    cfg_write(0, 32'h1); cfg_write(1, 32'hBEEF); cfg_read(1, rd);
    check("R2 odd select", rd, 32'h0);
    cfg_write(0, 32'h4); cfg_read(1, rd); check("R2 word 4-5", rd, 32'h5544);
    cfg_write(0, 32'h0); cfg_read(1, rd); check("R2 word 0-1", rd, 32'h1102);

    send_frame("R5", st, 0);
    cfg_write(0, 32'h0800_0000);
    cfg_write(0, 32'h8800_0000);
    cfg_read(0, rd); check("R3 select readback", rd, 32'h8800_0000);
    send_frame("R8 exact", st, 0);
    check("R8 exact class", {30'b0, expect_res(st)}, {29'b0, 3'b101});
    send_frame("R8 bcast off", '1, 0);

    cfg_write(0, 32'hF800_0002);
    cfg_read(0, rd); check("R4 flags locked", rd, 32'h8800_0002);
    send_frame("R4 bcast still off", '1, 0);

    cfg_write(0, 32'h2000_0000);
    cfg_write(0, 32'hA000_0000);
    send_frame("R7 bcast not mc", '1, 0);
    send_frame("R7 multicast", 48'h0000_0000_5501, 0);
    check("R7 mc class", {29'b0, expect_res(48'h0000_0000_5501)}, 32'h6);

    cfg_write(0, 32'h4800_0000);
    cfg_write(0, 32'hC800_0000);
    drive_octets('1, 0, 3, 0);
    send_frame("R9 restart", st, 0);
    check("R9 exact", {29'b0, expect_res(st)}, 32'h5);
    send_frame("R10 gaps", '1, 1);

    send_frame("R6 base", st, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); rx_valid = 1; rx_sof = 0; rx_byte = 8'hFF;
      @(negedge clk); rx_valid = 0;
      check("R6 extra octet", {31'b0, res_valid}, 32'd0);
    end

    e = expect_res(st);
    drive_octets(st, 0, 5, 0);
    @(negedge clk); rx_valid = 1; rx_sof = 0; rx_byte = st[47:40];
    cfg_wr = 1; cfg_sel = 0; cfg_wdata = 32'h0;
    @(negedge clk); rx_valid = 0; cfg_wr = 0;
    model_wr(0, 32'h0);
    check("R11 same-cycle write", {res_valid, res_accept, res_class}, {1'b1, e});
    @(negedge clk);
    send_frame("R11 after disable", st, 0);

    for (int f = 0; f < 400; f++) begin
      if (f % 20 == 0) begin
        logic [3:0] fl;
        fl = 4'($urandom);
        cfg_write(0, {1'b0, fl, 27'h0});
        if ($urandom % 3 == 0) begin
          cfg_write(0, {16'h0, 16'(2 * ($urandom % 3))});
          cfg_write(1, $urandom);
        end
        cfg_write(0, {($urandom % 8 != 0), fl, 27'h0});
      end
      send_frame("R8 random", pick_addr(), $urandom % 2);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule